// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block drives the bus cycles a small 8-bit core needs to enter and leave a hardware interrupt handler. The core has a 16-bit address space. At each instruction boundary the core pulses `insn_done`. The sequencer then decides whether an interrupt is taken. A request is taken only if it is both pending and enabled, and only if the interrupt mask bit in the condition code byte is clear. When several requests qualify, the lowest source index wins. On entry the block:

- runs one dummy read;
- saves the return address, the index low byte, the accumulator and the condition code byte onto a stack that grows downwards, one byte per cycle;
- reads a two-byte handler address, high byte first;
- issues the first opcode fetch at that handler address.

On the same final cycle it hands the new program counter, the stack pointer and the condition code byte (with the mask bit now set) back to the core through load strobes.

A return request (`rti_req`) reverses the process. The block reads the five saved bytes back in the opposite order and prefetches the opcode at the restored address. It then reloads every saved register. If an enabled request is waiting and the restored mask bit is clear, that prefetch is thrown away: `resume` stays low and stacking for the new source begins on the very next cycle, with no dummy read. The index high byte is never saved or restored.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `mem_act`, `mem_we`, `op_fetch`, `resume` and every load strobe are low.
- R2: An `insn_done` pulse starts entry only when (`irq_pend` & `irq_en`) is nonzero and bit 3 of `ccr_in` (the mask bit) is 0. Otherwise no bus cycle follows and `busy` stays low.
- R3: The source taken is the lowest index k with pending and enable both set. Its handler address high byte is read from `VEC_TOP - 2k` and its low byte from the next address, in that order.
- R4: Entry begins with a read at `pc_in` on the cycle after the `insn_done` edge. Five writes follow on consecutive cycles: PC low byte at `sp_in`, PC high byte at `sp_in-1`, X at `sp_in-2`, A at `sp_in-3`, and the condition code byte as received at `sp_in-4`.
- R5: After the two handler-address reads, one opcode fetch cycle is issued at that address with `op_fetch` and `resume` high. In the same cycle `ld_pc` loads that address, `ld_ccr` loads the saved condition code byte with bit 3 set, and `ld_sp` loads `sp_in-5`. `ld_x` and `ld_a` stay low.
- R6: A return reads `sp_in+1` through `sp_in+5` on consecutive cycles into CCR, A, X, PC high and PC low. The next cycle is an opcode fetch at the restored PC, during which `ld_pc`, `ld_x`, `ld_a`, `ld_ccr` and `ld_sp` (`sp_in+5`) all load the restored values.
- R7: In that return fetch cycle, if an enabled request is pending and bit 3 of the restored CCR is 0, `resume` is low. The next cycle writes the restored PC low byte at `sp_in+5`, and the entry continues as in R4/R5 for the new source, without a dummy read. If bit 3 of the restored CCR is 1, `resume` is high and the block goes idle.
- R8: Every bus cycle moves one byte. A plain entry keeps `busy` high for exactly 9 cycles and a plain return for exactly 6.
- R9: `insn_done` and `rti_req` have no effect while `busy` is high. The bus sequence in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Instruction boundary pulse |
| rti_req | input | 1 | Return-from-interrupt request pulse |
| irq_pend | input | NSRC | Pending request per source |
| irq_en | input | NSRC | Enable per source |
| pc_in | input | AW | Core program counter (return address) |
| x_in | input | DW | Core index low byte |
| a_in | input | DW | Core accumulator |
| ccr_in | input | DW | Core condition code byte, mask at bit IBIT |
| sp_in | input | AW | Core stack pointer |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| mem_act | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Write data |
| op_fetch | output | 1 | Current read is an opcode fetch |
| resume | output | 1 | Core executes the fetched opcode next |
| busy | output | 1 | Sequence in progress |
| ld_pc | output | 1 | Load PC strobe |
| pc_out | output | AW | PC load value |
| ld_x | output | 1 | Load X strobe |
| x_out | output | DW | X load value |
| ld_a | output | 1 | Load A strobe |
| a_out | output | DW | A load value |
| ld_ccr | output | 1 | Load CCR strobe |
| ccr_out | output | DW | CCR load value |
| ld_sp | output | 1 | Load SP strobe |
| sp_out | output | AW | SP load value |

## Verification
The bench sweeps every pending and enable pattern of four sources and compares each bus cycle's address, direction and data with values it works out itself. A wrong priority encoder shows up as a fetch from the wrong handler address, and a flipped push order shows up as bytes landing one slot off. The bench brings a saved frame back with nothing pending, then with a request pending, then with the mask bit set in the saved byte. A design that ignored the chained request would raise `resume` and run a stale prefetch. A design that reinserted the dummy read, or that read the mask from the live port instead of the restored byte, would produce a sequence one cycle longer or would wrongly chain. Boundary pulses injected mid-sequence catch a controller that restarts while busy.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // one state per bus cycle of the entry and return sequences
  typedef enum logic [3:0] {
    S_IDLE, S_DUMMY, S_PCL, S_PCH, S_PX, S_PA, S_PCCR, S_VH, S_VL, S_VFETCH,
    S_RCCR, S_RA, S_RX, S_RPCH, S_RPCL, S_RFETCH
  } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 4,
  parameter int IW   = 2
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [NSRC-1:0] live;

  for (genvar i = 0; i < NSRC; i++) begin : g_live
    assign live[i] = pend[i] & en[i];
  end

  // lowest index wins: scan downwards so the last match kept is the smallest
  always_comb begin
    hit = |live;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int             AW      = 16,
  parameter int             DW      = 8,
  parameter int             IW      = 2,
  parameter int             IBIT    = 3,
  parameter logic [AW-1:0]  VEC_TOP = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_done,
  input  logic          rti_req,
  input  logic          hit,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_act,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          op_fetch,
  output logic          resume,
  output logic          busy,
  output logic          ld_pc,
  output logic [AW-1:0] pc_out,
  output logic          ld_x,
  output logic [DW-1:0] x_out,
  output logic          ld_a,
  output logic [DW-1:0] a_out,
  output logic          ld_ccr,
  output logic [DW-1:0] ccr_out,
  output logic          ld_sp,
  output logic [AW-1:0] sp_out
);
  localparam logic [AW-1:0] FRAME = AW'(5);
  localparam logic [DW-1:0] IMASK = DW'(1) << IBIT;

  seq_state_e    st;
  logic [AW-1:0] pc_r, sp_r;
  logic [DW-1:0] x_r, a_r, ccr_r, vhi_r;
  logic [IW-1:0] k_r;
  logic [AW-1:0] vec_addr;
  logic          idle_take, chain_take;

  assign idle_take  = insn_done & hit & ~ccr_in[IBIT];
  assign chain_take = hit & ~ccr_r[IBIT];
  assign vec_addr   = VEC_TOP - {{(AW-IW-1){1'b0}}, k_r, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      pc_r  <= '0;
      sp_r  <= '0;
      x_r   <= '0;
      a_r   <= '0;
      ccr_r <= '0;
      vhi_r <= '0;
      k_r   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rti_req) begin
            sp_r <= sp_in;
            st   <= S_RCCR;
          end else if (idle_take) begin
            pc_r  <= pc_in;
            x_r   <= x_in;
            a_r   <= a_in;
            ccr_r <= ccr_in;
            sp_r  <= sp_in;
            k_r   <= idx;
            st    <= S_DUMMY;
          end
        end
        S_DUMMY: st <= S_PCL;
        S_PCL:   st <= S_PCH;
        S_PCH:   st <= S_PX;
        S_PX:    st <= S_PA;
        S_PA:    st <= S_PCCR;
        S_PCCR:  st <= S_VH;
        S_VH: begin
          vhi_r <= mem_rdata;
          st    <= S_VL;
        end
        S_VL: begin
          pc_r <= {vhi_r, mem_rdata};
          st   <= S_VFETCH;
        end
        S_VFETCH: st <= S_IDLE;
        S_RCCR: begin ccr_r <= mem_rdata;           st <= S_RA;    end
        S_RA:   begin a_r <= mem_rdata;             st <= S_RX;    end
        S_RX:   begin x_r <= mem_rdata;             st <= S_RPCH;  end
        S_RPCH: begin pc_r[AW-1:DW] <= mem_rdata;   st <= S_RPCL;  end
        S_RPCL: begin pc_r[DW-1:0] <= mem_rdata;    st <= S_RFETCH; end
        S_RFETCH: begin
          if (chain_take) begin
            sp_r <= sp_r + FRAME;
            k_r  <= idx;
            st   <= S_PCL;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // bus and load strobes decoded from the registered state and context
  always_comb begin
    mem_act   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    op_fetch  = 1'b0;
    resume    = 1'b0;
    ld_pc     = 1'b0;
    ld_x      = 1'b0;
    ld_a      = 1'b0;
    ld_ccr    = 1'b0;
    ld_sp     = 1'b0;
    pc_out    = pc_r;
    x_out     = x_r;
    a_out     = a_r;
    ccr_out   = (st == S_VFETCH) ? (ccr_r | IMASK) : ccr_r;
    sp_out    = (st == S_VFETCH) ? (sp_r - FRAME) : (sp_r + FRAME);
    case (st)
      S_DUMMY: begin mem_act = 1'b1; mem_addr = pc_r; end
      S_PCL:   begin mem_act = 1'b1; mem_we = 1'b1; mem_addr = sp_r;            mem_wdata = pc_r[DW-1:0];  end
      S_PCH:   begin mem_act = 1'b1; mem_we = 1'b1; mem_addr = sp_r - AW'(1);   mem_wdata = pc_r[AW-1:DW]; end
      S_PX:    begin mem_act = 1'b1; mem_we = 1'b1; mem_addr = sp_r - AW'(2);   mem_wdata = x_r;           end
      S_PA:    begin mem_act = 1'b1; mem_we = 1'b1; mem_addr = sp_r - AW'(3);   mem_wdata = a_r;           end
      S_PCCR:  begin mem_act = 1'b1; mem_we = 1'b1; mem_addr = sp_r - AW'(4);   mem_wdata = ccr_r;         end
      S_VH:    begin mem_act = 1'b1; mem_addr = vec_addr; end
      S_VL:    begin mem_act = 1'b1; mem_addr = vec_addr + AW'(1); end
      S_VFETCH: begin
        mem_act  = 1'b1;
        mem_addr = pc_r;
        op_fetch = 1'b1;
        resume   = 1'b1;
        ld_pc    = 1'b1;
        ld_ccr   = 1'b1;
        ld_sp    = 1'b1;
      end
      S_RCCR:  begin mem_act = 1'b1; mem_addr = sp_r + AW'(1); end
      S_RA:    begin mem_act = 1'b1; mem_addr = sp_r + AW'(2); end
      S_RX:    begin mem_act = 1'b1; mem_addr = sp_r + AW'(3); end
      S_RPCH:  begin mem_act = 1'b1; mem_addr = sp_r + AW'(4); end
      S_RPCL:  begin mem_act = 1'b1; mem_addr = sp_r + AW'(5); end
      S_RFETCH: begin
        mem_act  = 1'b1;
        mem_addr = pc_r;
        op_fetch = 1'b1;
        resume   = ~chain_take;
        ld_pc    = 1'b1;
        ld_x     = 1'b1;
        ld_a     = 1'b1;
        ld_ccr   = 1'b1;
        ld_sp    = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int            NSRC    = 4,
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter int            IBIT    = 3,
  parameter logic [AW-1:0] VEC_TOP = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_done,
  input  logic            rti_req,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic [AW-1:0]   pc_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   ccr_in,
  input  logic [AW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_act,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            op_fetch,
  output logic            resume,
  output logic            busy,
  output logic            ld_pc,
  output logic [AW-1:0]   pc_out,
  output logic            ld_x,
  output logic [DW-1:0]   x_out,
  output logic            ld_a,
  output logic [DW-1:0]   a_out,
  output logic            ld_ccr,
  output logic [DW-1:0]   ccr_out,
  output logic            ld_sp,
  output logic [AW-1:0]   sp_out
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic          hit;
  logic [IW-1:0] idx;

  irq_prio_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
    .pend (irq_pend),
    .en   (irq_en),
    .hit  (hit),
    .idx  (idx)
  );

  irq_seq_ctrl #(
    .AW(AW), .DW(DW), .IW(IW), .IBIT(IBIT), .VEC_TOP(VEC_TOP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .rti_req   (rti_req),
    .hit       (hit),
    .idx       (idx),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .ccr_in    (ccr_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .mem_act   (mem_act),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .op_fetch  (op_fetch),
    .resume    (resume),
    .busy      (busy),
    .ld_pc     (ld_pc),
    .pc_out    (pc_out),
    .ld_x      (ld_x),
    .x_out     (x_out),
    .ld_a      (ld_a),
    .a_out     (a_out),
    .ld_ccr    (ld_ccr),
    .ccr_out   (ccr_out),
    .ld_sp     (ld_sp),
    .sp_out    (sp_out)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int IBIT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_done,
  input logic          rti_req,
  input logic [DW-1:0] ccr_in,
  input logic          busy,
  input logic          mem_act,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          op_fetch,
  input logic          resume,
  input logic          ld_pc,
  input logic [AW-1:0] pc_out,
  input logic          ld_x,
  input logic [DW-1:0] ccr_out
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !mem_act && !ld_pc));

  assert_masked_stays_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && insn_done && !rti_req && ccr_in[IBIT]) |=> !busy);

  assert_push_descends_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  assert_fetch_loads_pc_R5: assert property (@(posedge clk) disable iff (rst)
    op_fetch |-> (ld_pc && mem_act && !mem_we && mem_addr == pc_out));

  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (rst)
    (op_fetch && resume && !ld_x) |-> ccr_out[IBIT]);

  assert_one_byte_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_we || op_fetch) |-> (mem_act && busy && !(mem_we && op_fetch)));

  assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(insn_done || rti_req));
endmodule

bind irq_entry_seq irq_seq_chk #(.AW(AW), .DW(DW), .IBIT(IBIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn_done (insn_done),
  .rti_req   (rti_req),
  .ccr_in    (ccr_in),
  .busy      (busy),
  .mem_act   (mem_act),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .op_fetch  (op_fetch),
  .resume    (resume),
  .ld_pc     (ld_pc),
  .pc_out    (pc_out),
  .ld_x      (ld_x),
  .ccr_out   (ccr_out)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_done = 1'b0, rti_req = 1'b0;
  logic [3:0]  irq_pend = '0, irq_en = '0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
  logic [7:0]  mem_rdata;
  logic        mem_act, mem_we, op_fetch, resume, busy;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata, x_out, a_out, ccr_out;
  logic        ld_pc, ld_x, ld_a, ld_ccr, ld_sp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .insn_done(insn_done), .rti_req(rti_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .ccr_in(ccr_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .mem_act(mem_act), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .op_fetch(op_fetch), .resume(resume),
    .busy(busy), .ld_pc(ld_pc), .pc_out(pc_out), .ld_x(ld_x),
    .x_out(x_out), .ld_a(ld_a), .a_out(a_out), .ld_ccr(ld_ccr),
    .ccr_out(ccr_out), .ld_sp(ld_sp), .sp_out(sp_out)
  );

  // memory model: 256-byte page mirrored below FF00, handler table above
  logic [7:0]  stk [256];
  logic        poke = 1'b0;
  logic [7:0]  poke_a = '0, poke_d = '0;

  function automatic logic [7:0] vec_byte(input logic [15:0] a);
    return a[0] ? (a[7:0] ^ 8'h5A) : (8'h40 + {4'b0, a[3:0]});
  endfunction

  always @(posedge clk) begin
    if (poke) stk[poke_a] <= poke_d;
    else if (mem_act && mem_we) stk[mem_addr[7:0]] <= mem_wdata;
  end

  assign mem_rdata = (mem_addr >= 16'hFF00) ? vec_byte(mem_addr) : stk[mem_addr[7:0]];

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one bus cycle, compared at the negative edge; optionally fire stray requests
  task automatic cyc(input string req, input logic we, input logic [15:0] addr,
                     input logic [7:0] wd, input logic fetch, input logic res,
                     input bit stray);
    check(req, "busy", busy, 1);
    check(req, "mem_act", mem_act, 1);
    check(req, "mem_we", mem_we, we);
    check(req, "mem_addr", mem_addr, addr);
    if (we) check(req, "mem_wdata", mem_wdata, wd);
    check(req, "op_fetch", op_fetch, fetch);
    check(req, "resume", resume, res);
    if (stray) begin insn_done = 1'b1; rti_req = 1'b1; end
    @(negedge clk);
    insn_done = 1'b0;
    rti_req   = 1'b0;
  endtask

  function automatic int pick(input logic [3:0] live);
    for (int i = 0; i < 4; i++) if (live[i]) return i;
    return -1;
  endfunction

  // stacking, handler address reads and first fetch, starting at the PC-low write
  task automatic push_tail(input string req, input logic [15:0] pc, input logic [7:0] x,
                           input logic [7:0] a, input logic [7:0] ccr,
                           input logic [15:0] sp, input int k, input bit stray);
    logic [15:0] va, st_addr;
    va = 16'hFFFC - 16'(2 * k);
    st_addr = {vec_byte(va), vec_byte(va + 16'd1)};
    cyc({req, "/R4"}, 1, sp,          pc[7:0],  0, 0, 0);
    cyc({req, "/R4"}, 1, sp - 16'd1,  pc[15:8], 0, 0, stray);
    cyc({req, "/R4"}, 1, sp - 16'd2,  x,        0, 0, 0);
    cyc({req, "/R4"}, 1, sp - 16'd3,  a,        0, 0, stray);
    cyc({req, "/R4"}, 1, sp - 16'd4,  ccr,      0, 0, 0);
    cyc({req, "/R3"}, 0, va,          0,        0, 0, 0);
    cyc({req, "/R3"}, 0, va + 16'd1,  0,        0, 0, 0);
    check("R5", "ld_pc", ld_pc, 1);
    check("R5", "pc_out", pc_out, st_addr);
    check("R5", "ld_ccr", ld_ccr, 1);
    check("R5", "ccr_out", ccr_out, ccr | 8'h08);
    check("R5", "ld_sp", ld_sp, 1);
    check("R5", "sp_out", sp_out, sp - 16'd5);
    check("R5", "ld_x/ld_a", {ld_x, ld_a}, 0);
    cyc("R5", 0, st_addr, 0, 1, 1, 0);
    check("R8", "busy after entry", busy, 0);
    check("R8", "mem_act after entry", mem_act, 0);
  endtask

  task automatic do_entry(input logic [3:0] pend, input logic [3:0] en,
                          input logic [7:0] ccr, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] a,
                          input logic [15:0] sp, input bit stray);
    int k;
    irq_pend = pend; irq_en = en; ccr_in = ccr; pc_in = pc;
    x_in = x; a_in = a; sp_in = sp; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    k = pick(pend & en);
    if (k < 0 || ccr[3]) begin
      for (int i = 0; i < 3; i++) begin
        check("R2", "busy when not taken", busy, 0);
        check("R2", "mem_act when not taken", mem_act, 0);
        @(negedge clk);
      end
    end else begin
      cyc("R4", 0, pc, 0, 0, 0, stray);
      push_tail(stray ? "R9" : "R2", pc, x, a, ccr, sp, k, stray);
    end
    irq_pend = '0;
  endtask

  task automatic do_rti(input logic [15:0] sp, input logic [7:0] ccr, input logic [7:0] a,
                        input logic [7:0] x, input logic [15:0] pc, input int chain_k);
    sp_in = sp; rti_req = 1'b1;
    @(negedge clk);
    rti_req = 1'b0;
    cyc("R6", 0, sp + 16'd1, 0, 0, 0, 0);
    cyc("R6", 0, sp + 16'd2, 0, 0, 0, 0);
    cyc("R6", 0, sp + 16'd3, 0, 0, 0, 0);
    cyc("R6", 0, sp + 16'd4, 0, 0, 0, 0);
    cyc("R6", 0, sp + 16'd5, 0, 0, 0, 0);
    check("R6", "ld strobes", {ld_pc, ld_x, ld_a, ld_ccr, ld_sp}, 5'b11111);
    check("R6", "pc_out", pc_out, pc);
    check("R6", "x_out", x_out, x);
    check("R6", "a_out", a_out, a);
    check("R6", "ccr_out", ccr_out, ccr);
    check("R6", "sp_out", sp_out, sp + 16'd5);
    if (chain_k >= 0) begin
      cyc("R7", 0, pc, 0, 1, 0, 0);
      push_tail("R7", pc, x, a, ccr, sp + 16'd5, chain_k, 0);
    end else begin
      cyc("R7", 0, pc, 0, 1, 1, 0);
      check("R8", "busy after return", busy, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "mem_act", mem_act, 0);
    check("R1", "strobes", {mem_we, op_fetch, resume, ld_pc, ld_x, ld_a, ld_ccr, ld_sp}, 0);

    // mask bit set: nothing happens
    do_entry(4'b0010, 4'hF, 8'h08, 16'h2222, 8'h01, 8'h02, 16'h00F0, 0);

    // every pending x enable pattern with the mask clear
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        do_entry(4'(p), 4'(e), 8'hA0 | {5'b0, 3'(p)},
                 16'h1003 | 16'(p << 8) | 16'(e << 4),
                 8'h10 + 8'(p), 8'h20 + 8'(e), 16'h00F0 - 16'(e), 0);
      end
    end

    // stray boundary/return pulses while busy (R9), leaves frame at F0..EC
    do_entry(4'b1000, 4'hF, 8'h00, 16'h1234, 8'h56, 8'h78, 16'h00F0, 1);
    // plain return, nothing pending
    do_rti(16'h00EB, 8'h00, 8'h78, 8'h56, 16'h1234, -1);

    // return with a pending request: chained entry for source 1
    do_entry(4'b0001, 4'hF, 8'h00, 16'h1234, 8'h56, 8'h78, 16'h00F0, 0);
    irq_pend = 4'b0110; irq_en = 4'hF;
    do_rti(16'h00EB, 8'h00, 8'h78, 8'h56, 16'h1234, 1);

    // saved CCR has the mask set: no chaining even though a request waits
    poke_a = 8'hEC; poke_d = 8'h08; poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
    irq_pend = 4'b0110;
    do_rti(16'h00EB, 8'h08, 8'h78, 8'h56, 16'h1234, -1);
    irq_pend = '0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule